// File: doc/BRIEF.md
# Host Data Register Handshake Unit

This block holds a small bank of byte-wide mailbox registers shared by an external host, which runs on no clock of its own, and a local processor core. The host raises a write or read strobe with a register select and data held steady. The strobe is brought into the core clock domain through a synchronizer chain. The block answers with an acknowledge that stays high until the host drops its strobe. The core reads and writes the same registers on its own clock through a plain enable-and-address port.

Each register carries two flags. One flag marks data written by the host that the core has not yet read. The other marks data written by the core that the host has not yet read. A single mode bit, written by the core, sets how a host write treats unread data. With the bit set, the write lands at once and replaces the old value. With the bit clear, the acknowledge is withheld until the core has read the pending value, and only then does the write complete. The mode bit comes out of reset set. A host that ignores the acknowledge can therefore never be stalled.

Top module: `hdr_bank`

## Requirements
- R1: After reset every flag in both flag vectors is 0, every register holds 0, `host_ack` is 0 and `ovw_mode` is 1.
- R2: With `ovw_mode` = 1, a host write stores `host_wdata` into register `host_sel` and sets its bit in `from_host_full`, even when that bit was already set. `host_ack` rises within SYNC_STAGES+2 core clock cycles of the strobe rising.
- R3: `host_ack` stays high for as long as the host keeps its strobe high. It falls within SYNC_STAGES+2 cycles after the strobe falls.
- R4: With `ovw_mode` = 0 and the target bit of `from_host_full` set, a host write leaves the register unchanged and keeps `host_ack` low. Once the core reads that register, the write completes, the bit is set again and `host_ack` rises.
- R5: With `ovw_mode` = 0 and the target bit of `from_host_full` clear, a host write completes with the same latency as in R2.
- R6: `core_rdata` always shows register `core_addr`. A cycle with `core_rd_en` = 1 clears bit `core_addr` of `from_host_full` and leaves every other bit unchanged.
- R7: A cycle with `core_wr_en` = 1 stores `core_wdata` into register `core_addr` and sets its bit in `to_host_full`. It leaves `from_host_full` untouched.
- R8: `host_rdata` shows register `host_sel`. A host read strobe is acknowledged as in R2 and clears bit `host_sel` of `to_host_full`.
- R9: A cycle with `ovw_wr_en` = 1 loads `ovw_wdata` into `ovw_mode`.
- R10: A `host_sel` value of NUM_REGS or more selects no register. A host write to it is acknowledged but changes no register or flag, and `host_rdata` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_strb | input | 1 | Host write strobe, asynchronous, level |
| host_rd_strb | input | 1 | Host read strobe, asynchronous, level |
| host_sel | input | ADDR_W | Host register select, steady while a strobe is high |
| host_wdata | input | DATA_W | Host write data, steady while the write strobe is high |
| host_rdata | output | DATA_W | Contents of the host-selected register |
| host_ack | output | 1 | Host handshake acknowledge |
| core_addr | input | ADDR_W | Core register address |
| core_wr_en | input | 1 | Core write enable |
| core_rd_en | input | 1 | Core read enable (consumes host data) |
| core_wdata | input | DATA_W | Core write data |
| core_rdata | output | DATA_W | Contents of the core-addressed register |
| ovw_wr_en | input | 1 | Load enable for the mode bit |
| ovw_wdata | input | 1 | New mode bit value |
| ovw_mode | output | 1 | Current mode: 1 = overwrite, 0 = hold until read |
| from_host_full | output | NUM_REGS | Per register: host wrote, core has not read |
| to_host_full | output | NUM_REGS | Per register: core wrote, host has not read |

## Verification
The bench uses the default parameters: six 8-bit registers, a two-stage synchronizer and overwrite mode set at reset. A 3-bit select then has two codes, 6 and 7, that map to no register, so the out-of-range case in R10 can be driven directly. The two-stage chain bounds every acknowledge within four cycles, which makes a stalled acknowledge in hold mode easy to tell apart from a slow one. The vector walk runs in the reset overwrite mode. The directed tests then clear the mode bit and exercise the hold path.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_WAIT = 2'd1,
      HS_ACK  = 2'd2
   } hs_state_e;

   function automatic int unsigned sel_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/hdr_sync.sv
module hdr_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hdr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hdr_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= async_in;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/hdr_cell.sv
module hdr_cell #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_rd_clr,
   input  logic              core_we,
   input  logic              core_rd_clr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] core_wdata,
   output logic [DATA_W-1:0] data_q,
   output logic              from_host_full,
   output logic              to_host_full
);

   // Host write wins the storage if both sides write in one cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (host_we) data_q <= host_wdata;
      else if (core_we) data_q <= core_wdata;
   end

   // Setting a flag takes precedence over clearing it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           from_host_full <= 1'b0;
      else if (host_we)     from_host_full <= 1'b1;
      else if (core_rd_clr) from_host_full <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           to_host_full <= 1'b0;
      else if (core_we)     to_host_full <= 1'b1;
      else if (host_rd_clr) to_host_full <= 1'b0;
   end

   a_r2_host_store: assert property (@(posedge clk) disable iff (!rst_n)
      host_we |=> (data_q == $past(host_wdata)) && from_host_full);

   a_r6_core_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      core_rd_clr && !host_we |=> !from_host_full);

   a_r7_core_store: assert property (@(posedge clk) disable iff (!rst_n)
      core_we && !host_we |=> (data_q == $past(core_wdata)) && to_host_full);

   a_r7_core_keeps_host_flag: assert property (@(posedge clk) disable iff (!rst_n)
      core_we && !host_we && !core_rd_clr |=> from_host_full == $past(from_host_full));

   a_r8_host_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_clr && !core_we |=> !to_host_full);

endmodule

// File: rtl/hdr_host_fsm.sv
module hdr_host_fsm
   import hdr_pkg::*;
#(
   parameter int unsigned NUM_REGS = 6,
   parameter int unsigned ADDR_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_req,
   input  logic                rd_req,
   input  logic [ADDR_W-1:0]   host_sel,
   input  logic                ovw_mode,
   input  logic [NUM_REGS-1:0] full_vec,
   output logic                ack,
   output logic                wr_go,
   output logic                rd_go
);

   hs_state_e state_q, state_d;
   logic      tgt_full;
   logic      may_write;

   // An out-of-range select never counts as holding unread data.
   always_comb begin
      tgt_full = 1'b0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (host_sel == ADDR_W'(i)) tgt_full = full_vec[i];
      end
   end

   assign may_write = ovw_mode || !tgt_full;

   always_comb begin
      state_d = state_q;
      wr_go   = 1'b0;
      rd_go   = 1'b0;
      unique case (state_q)
         HS_IDLE: begin
            if (wr_req) begin
               if (may_write) begin
                  wr_go   = 1'b1;
                  state_d = HS_ACK;
               end else begin
                  state_d = HS_WAIT;
               end
            end else if (rd_req) begin
               rd_go   = 1'b1;
               state_d = HS_ACK;
            end
         end
         HS_WAIT: begin
            if (!wr_req) begin
               state_d = HS_IDLE;
            end else if (may_write) begin
               wr_go   = 1'b1;
               state_d = HS_ACK;
            end
         end
         HS_ACK: begin
            if (!wr_req && !rd_req) state_d = HS_IDLE;
         end
         default: state_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= HS_IDLE;
      else        state_q <= state_d;
   end

   assign ack = (state_q == HS_ACK);

   a_r3_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
      ack && (wr_req || rd_req) |=> ack);

   a_r3_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
      ack && !wr_req && !rd_req |=> !ack);

   a_r4_wait_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == HS_WAIT) && !may_write |=> !ack);

   a_r2_single_action: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_go && rd_go));

endmodule

// File: rtl/hdr_bank.sv
module hdr_bank
   import hdr_pkg::*;
#(
   parameter int unsigned NUM_REGS    = 6,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OVW_RESET   = 1'b1,
   localparam int unsigned ADDR_W     = sel_bits(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_wr_strb,
   input  logic                host_rd_strb,
   input  logic [ADDR_W-1:0]   host_sel,
   input  logic [DATA_W-1:0]   host_wdata,
   output logic [DATA_W-1:0]   host_rdata,
   output logic                host_ack,
   input  logic [ADDR_W-1:0]   core_addr,
   input  logic                core_wr_en,
   input  logic                core_rd_en,
   input  logic [DATA_W-1:0]   core_wdata,
   output logic [DATA_W-1:0]   core_rdata,
   input  logic                ovw_wr_en,
   input  logic                ovw_wdata,
   output logic                ovw_mode,
   output logic [NUM_REGS-1:0] from_host_full,
   output logic [NUM_REGS-1:0] to_host_full
);

   if (NUM_REGS < 2) begin : g_bad_regs
      $error("hdr_bank: NUM_REGS must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("hdr_bank: DATA_W must be at least 1");
   end
   if ((2 ** ADDR_W) < NUM_REGS) begin : g_bad_addr
      $error("hdr_bank: select width too narrow");
   end

   logic [1:0]          strb_sync;
   logic                wr_req, rd_req;
   logic                wr_go, rd_go;
   logic [NUM_REGS-1:0] host_we, host_rd_clr, core_we, core_rd_clr;
   logic [DATA_W-1:0]   cell_data [NUM_REGS];
   logic                sel_valid;

   hdr_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({host_rd_strb, host_wr_strb}),
      .sync_out (strb_sync)
   );

   assign wr_req = strb_sync[0];
   assign rd_req = strb_sync[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ovw_mode <= OVW_RESET;
      else if (ovw_wr_en) ovw_mode <= ovw_wdata;
   end

   hdr_host_fsm #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req   (wr_req),
      .rd_req   (rd_req),
      .host_sel (host_sel),
      .ovw_mode (ovw_mode),
      .full_vec (from_host_full),
      .ack      (host_ack),
      .wr_go    (wr_go),
      .rd_go    (rd_go)
   );

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
      assign host_we[g]     = wr_go      && (host_sel  == ADDR_W'(g));
      assign host_rd_clr[g] = rd_go      && (host_sel  == ADDR_W'(g));
      assign core_we[g]     = core_wr_en && (core_addr == ADDR_W'(g));
      assign core_rd_clr[g] = core_rd_en && (core_addr == ADDR_W'(g));

      hdr_cell #(
         .DATA_W (DATA_W)
      ) u_cell (
         .clk            (clk),
         .rst_n          (rst_n),
         .host_we        (host_we[g]),
         .host_rd_clr    (host_rd_clr[g]),
         .core_we        (core_we[g]),
         .core_rd_clr    (core_rd_clr[g]),
         .host_wdata     (host_wdata),
         .core_wdata     (core_wdata),
         .data_q         (cell_data[g]),
         .from_host_full (from_host_full[g]),
         .to_host_full   (to_host_full[g])
      );

      a_r4_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
         host_we[g] && !ovw_mode |-> !from_host_full[g]);
   end

   always_comb begin
      host_rdata = '0;
      core_rdata = '0;
      sel_valid  = 1'b0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (host_sel == ADDR_W'(i)) begin
            host_rdata = cell_data[i];
            sel_valid  = 1'b1;
         end
         if (core_addr == ADDR_W'(i)) core_rdata = cell_data[i];
      end
   end

   a_r9_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
      ovw_wr_en |=> ovw_mode == $past(ovw_wdata));

   a_r10_bad_sel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |-> (host_we == '0) && (host_rd_clr == '0));

   a_r10_bad_sel_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |-> host_rdata == '0);

endmodule

// File: tb/tb_hdr_bank.sv
module tb_hdr_bank;

   localparam int CLK_PERIOD = 10;
   localparam int NR   = 6;
   localparam int DW   = 8;
   localparam int AW   = 3;
   localparam int ALAT = 4;  // SYNC_STAGES + 2

   localparam logic [1:0] OP_HW = 2'd0, OP_CR = 2'd1, OP_CW = 2'd2, OP_HR = 2'd3;
   localparam int NVEC = 12;
   // {op, addr, data}
   localparam logic [12:0] VEC [NVEC] = '{
      {OP_HW, 3'd0, 8'hA1}, {OP_HW, 3'd1, 8'hB2}, {OP_CR, 3'd0, 8'hA1},
      {OP_CW, 3'd4, 8'hC3}, {OP_HR, 3'd4, 8'hC3}, {OP_HW, 3'd5, 8'hD4},
      {OP_CR, 3'd5, 8'hD4}, {OP_CW, 3'd1, 8'hE5}, {OP_CR, 3'd1, 8'hE5},
      {OP_HR, 3'd1, 8'hE5}, {OP_HW, 3'd0, 8'h0F}, {OP_CR, 3'd0, 8'h0F}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_wr_strb = 1'b0, host_rd_strb = 1'b0;
   logic [AW-1:0] host_sel = '0, core_addr = '0;
   logic [DW-1:0] host_wdata = '0, core_wdata = '0;
   logic core_wr_en = 1'b0, core_rd_en = 1'b0, ovw_wr_en = 1'b0, ovw_wdata = 1'b0;
   logic [DW-1:0] host_rdata, core_rdata;
   logic host_ack, ovw_mode;
   logic [NR-1:0] from_host_full, to_host_full;

   logic [NR-1:0] exp_hf = '0, exp_cf = '0;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hdr_bank dut (
      .clk(clk), .rst_n(rst_n),
      .host_wr_strb(host_wr_strb), .host_rd_strb(host_rd_strb),
      .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_ack(host_ack),
      .core_addr(core_addr), .core_wr_en(core_wr_en), .core_rd_en(core_rd_en),
      .core_wdata(core_wdata), .core_rdata(core_rdata),
      .ovw_wr_en(ovw_wr_en), .ovw_wdata(ovw_wdata), .ovw_mode(ovw_mode),
      .from_host_full(from_host_full), .to_host_full(to_host_full)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_flags(input string req);
      check(from_host_full == exp_hf, req, "from_host_full", 32'(from_host_full), 32'(exp_hf));
      check(to_host_full == exp_cf, req, "to_host_full", 32'(to_host_full), 32'(exp_cf));
   endtask

   task automatic wait_ack(input logic level, output int cyc);
      cyc = 0;
      while (host_ack !== level && cyc < 40) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic host_wr_begin(input logic [AW-1:0] a, input logic [DW-1:0] d);
      host_sel = a;
      host_wdata = d;
      host_wr_strb = 1'b1;
   endtask

   task automatic host_release(input string req);
      int c;
      host_wr_strb = 1'b0;
      host_rd_strb = 1'b0;
      wait_ack(1'b0, c);
      check(c <= ALAT && !host_ack, req, "ack release latency", 32'(c), ALAT);
   endtask

   task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
      int c;
      host_wr_begin(a, d);
      wait_ack(1'b1, c);
      check(c <= ALAT && host_ack, req, "write ack latency", 32'(c), ALAT);
      host_release("R3");
      if (a < NR) exp_hf[a] = 1'b1;
   endtask

   task automatic host_read(input logic [AW-1:0] a, input logic [DW-1:0] d);
      int c;
      host_sel = a;
      host_rd_strb = 1'b1;
      #1 check(host_rdata == d, "R8", "host_rdata", 32'(host_rdata), 32'(d));
      wait_ack(1'b1, c);
      check(c <= ALAT && host_ack, "R8", "read ack latency", 32'(c), ALAT);
      host_release("R3");
      exp_cf[a] = 1'b0;
   endtask

   task automatic core_read(input logic [AW-1:0] a, input logic [DW-1:0] d);
      core_addr = a;
      core_rd_en = 1'b1;
      #1 check(core_rdata == d, "R6", "core_rdata", 32'(core_rdata), 32'(d));
      @(negedge clk);
      core_rd_en = 1'b0;
      exp_hf[a] = 1'b0;
   endtask

   task automatic core_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      core_addr = a;
      core_wdata = d;
      core_wr_en = 1'b1;
      @(negedge clk);
      core_wr_en = 1'b0;
      exp_cf[a] = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_flags("R1");
      check(host_ack == 1'b0, "R1", "host_ack", 32'(host_ack), 0);
      check(ovw_mode == 1'b1, "R1", "ovw_mode", 32'(ovw_mode), 1);
      for (int i = 0; i < NR; i++) begin
         core_addr = AW'(i);
         #1 check(core_rdata == '0, "R1", "reset data", 32'(core_rdata), 0);
      end
      @(negedge clk);

      // Vector walk in overwrite mode (R2, R6, R7, R8)
      for (int v = 0; v < NVEC; v++) begin
         logic [1:0] op = VEC[v][12:11];
         logic [AW-1:0] a = VEC[v][10:8];
         logic [DW-1:0] d = VEC[v][7:0];
         case (op)
            OP_HW: host_write(a, d, "R2");
            OP_CR: core_read(a, d);
            OP_CW: core_write(a, d);
            default: host_read(a, d);
         endcase
         check_flags(op == OP_CW ? "R7" : (op == OP_HR ? "R8" : (op == OP_CR ? "R6" : "R2")));
      end

      // R2 overwrite of unread data
      host_write(3'd2, 8'h11, "R2");
      host_write(3'd2, 8'h22, "R2");
      check_flags("R2");
      core_read(3'd2, 8'h22);
      check_flags("R2");

      // R6 read clears only the addressed flag
      host_write(3'd0, 8'hAA, "R6");
      host_write(3'd5, 8'hBB, "R6");
      core_read(3'd0, 8'hAA);
      check_flags("R6");
      core_read(3'd5, 8'hBB);
      check_flags("R6");

      // R3 ack held while strobe stays high
      host_wr_begin(3'd4, 8'h44);
      wait_ack(1'b1, c);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check(host_ack == 1'b1, "R3", "ack held", 32'(host_ack), 1);
      end
      host_release("R3");
      exp_hf[4] = 1'b1;
      core_read(3'd4, 8'h44);
      check_flags("R3");

      // R10 out-of-range select
      host_write(3'd7, 8'h77, "R10");
      check_flags("R10");
      host_sel = 3'd6;
      #1 check(host_rdata == '0, "R10", "host_rdata", 32'(host_rdata), 0);
      @(negedge clk);

      // R9 clear the mode bit
      ovw_wdata = 1'b0;
      ovw_wr_en = 1'b1;
      @(negedge clk);
      ovw_wr_en = 1'b0;
      check(ovw_mode == 1'b0, "R9", "ovw_mode", 32'(ovw_mode), 0);

      // R5 hold mode, empty register
      host_write(3'd3, 8'h33, "R5");
      check_flags("R5");

      // R4 hold mode, unread data
      host_wr_begin(3'd3, 8'h5A);
      repeat (20) @(negedge clk);
      check(host_ack == 1'b0, "R4", "ack withheld", 32'(host_ack), 0);
      core_addr = 3'd3;
      #1 check(core_rdata == 8'h33, "R4", "data kept", 32'(core_rdata), 32'h33);
      @(negedge clk);
      core_read(3'd3, 8'h33);
      wait_ack(1'b1, c);
      check(c <= 3 && host_ack, "R4", "ack after core read", 32'(c), 3);
      host_release("R4");
      exp_hf[3] = 1'b1;
      check_flags("R4");
      core_read(3'd3, 8'h5A);
      check_flags("R4");

      // R9 set mode back
      ovw_wdata = 1'b1;
      ovw_wr_en = 1'b1;
      @(negedge clk);
      ovw_wr_en = 1'b0;
      check(ovw_mode == 1'b1, "R9", "ovw_mode", 32'(ovw_mode), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule